// File: doc/BRIEF.md
# Scan Shift Activity Estimator

This block scores the scan-chain switching cost of a single test vector. It receives the stimulus word that would be shifted into a scan chain and the response word that would be captured into it, both presented in parallel and as wide as the chain. A start strobe launches the evaluation. The block then walks the chain one adjacent flip-flop pair per clock. It accumulates three activity figures and their sum, and raises a done flag.

The shift figures are not plain transition counts. Bit 0 of each word is chain position 1, the scan-in end. A transition between positions p and p+1 is located at position p. While the stimulus is shifted in, that transition ripples through the flip-flops downstream of it. It is therefore charged chain length minus p. While the response is shifted out, a transition at p passes the flip-flops upstream of it. It is therefore charged p. Capture activity is the number of flip-flops whose loaded value differs from the captured value.

Software that orders vectors or chains can use the block to score candidates in hardware. The chain length is a parameter.

Top module: `scan_activity_est`

## Requirements
- R1: After reset, done is low and all four counts read zero.
- R2: shiftInCnt equals the sum of (CHAIN_LEN - p) over every position p in 1..CHAIN_LEN-1 where loadVec bit p-1 differs from loadVec bit p. Bit 0 is position 1.
- R3: shiftOutCnt equals the sum of p over every position p in 1..CHAIN_LEN-1 where respVec bit p-1 differs from respVec bit p.
- R4: captureCnt equals the number of bit positions where loadVec and respVec differ.
- R5: totalCnt equals shiftInCnt + shiftOutCnt + captureCnt.
- R6: Suppose start is sampled high on clock edge k. Then done is low after edges k through k+CHAIN_LEN-1 and high after edge k+CHAIN_LEN.
- R7: Once done is high, all counts and done stay unchanged until the next start. Changes on loadVec and respVec after the start edge do not affect the result.
- R8: A start sampled while an evaluation runs, or after done, clears done and the counts. It then restarts the evaluation on the vectors presented at that edge.
- R9: The counters hold the worst case without wrapping. With every adjacent pair toggling, each shift count reaches CHAIN_LEN*(CHAIN_LEN-1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the vectors and begin an evaluation |
| loadVec | input | CHAIN_LEN | Stimulus word; bit 0 is the scan-in end |
| respVec | input | CHAIN_LEN | Captured response word |
| shiftInCnt | output | clog2(CHAIN_LEN*(CHAIN_LEN-1)/2+1) | Weighted shift-in activity |
| shiftOutCnt | output | clog2(CHAIN_LEN*(CHAIN_LEN-1)/2+1) | Weighted shift-out activity |
| captureCnt | output | clog2(CHAIN_LEN+1) | Capture bit-flip count |
| totalCnt | output | clog2(CHAIN_LEN*CHAIN_LEN+1) | Sum of the three counts |
| done | output | 1 | Evaluation complete, results valid |

## Verification
The hardest case to reach is a start that lands in the middle of a running evaluation. Partial sums and a half-advanced pair index must both be discarded at that point. The bench fires a second start a few cycles into a run, with different vectors. It then checks the cycle count to done and every result against the second pair only.

Position weighting is exercised two ways. A single transition is placed at the first pair and another at the last pair, so the two weight extremes show up in the counts. Fully alternating words drive both shift counters to their ceiling.

// File: rtl/scan_activity_pkg.sv
package scan_activity_pkg;
  typedef struct packed {
    logic clear;
    logic step;
  } estCtrl_t;
endpackage

// File: rtl/scan_activity_ctrl.sv
module scan_activity_ctrl #(
  parameter int CHAIN_LEN = 16,
  localparam int IDXW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output scan_activity_pkg::estCtrl_t    ctrl,
  output logic [IDXW-1:0]                idx,
  output logic                           done
);
  import scan_activity_pkg::*;

  typedef enum logic [1:0] {IDLE, RUN, FIN} state_t;
  localparam logic [IDXW-1:0] LAST = IDXW'(CHAIN_LEN - 1);

  state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      idx   <= '0;
    end else if (start) begin
      state <= RUN;
      idx   <= '0;
    end else if (state == RUN) begin
      if (idx == LAST) begin
        state <= FIN;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.clear = start;
    ctrl.step  = (state == RUN) && !start;
  end

  assign done = (state == FIN);

  // R8
  restart_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R6
  done_after_last_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(idx) == LAST);

  // R7
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/scan_activity_dp.sv
module scan_activity_dp #(
  parameter int CHAIN_LEN = 16,
  localparam int IDXW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int SHMAX = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
  localparam int SHW  = $clog2(SHMAX + 1),
  localparam int CAPW = $clog2(CHAIN_LEN + 1),
  localparam int TOTW = $clog2(CHAIN_LEN * CHAIN_LEN + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  scan_activity_pkg::estCtrl_t ctrl,
  input  logic [IDXW-1:0]             idx,
  input  logic [CHAIN_LEN-1:0]        loadVec,
  input  logic [CHAIN_LEN-1:0]        respVec,
  output logic [SHW-1:0]              shiftInCnt,
  output logic [SHW-1:0]              shiftOutCnt,
  output logic [CAPW-1:0]             captureCnt,
  output logic [TOTW-1:0]             totalCnt
);
  localparam logic [IDXW-1:0] LAST = IDXW'(CHAIN_LEN - 1);

  logic [CHAIN_LEN-1:0] inSr, outSr;
  logic                 pairValid, inEdge, outEdge, capFlip;
  logic [IDXW-1:0]      inWeight, outWeight;
  logic [SHW-1:0]       inAdd, outAdd;
  logic [CAPW-1:0]      capAdd;
  logic [TOTW-1:0]      totAdd;

  always_comb begin
    pairValid = (idx != LAST);
    inEdge    = pairValid && (inSr[0]  ^ inSr[1]);
    outEdge   = pairValid && (outSr[0] ^ outSr[1]);
    capFlip   = inSr[0] ^ outSr[0];
    inWeight  = LAST - idx;
    outWeight = idx + 1'b1;
    inAdd     = inEdge  ? SHW'(inWeight)  : '0;
    outAdd    = outEdge ? SHW'(outWeight) : '0;
    capAdd    = capFlip ? CAPW'(1)        : '0;
    totAdd    = TOTW'(inAdd) + TOTW'(outAdd) + TOTW'(capAdd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inSr        <= '0;
      outSr       <= '0;
      shiftInCnt  <= '0;
      shiftOutCnt <= '0;
      captureCnt  <= '0;
      totalCnt    <= '0;
    end else if (ctrl.clear) begin
      inSr        <= loadVec;
      outSr       <= respVec;
      shiftInCnt  <= '0;
      shiftOutCnt <= '0;
      captureCnt  <= '0;
      totalCnt    <= '0;
    end else if (ctrl.step) begin
      inSr        <= inSr  >> 1;
      outSr       <= outSr >> 1;
      shiftInCnt  <= shiftInCnt  + inAdd;
      shiftOutCnt <= shiftOutCnt + outAdd;
      captureCnt  <= captureCnt  + capAdd;
      totalCnt    <= totalCnt    + totAdd;
    end
  end

  // R7
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clear && !ctrl.step) |=> ($stable(shiftInCnt) && $stable(shiftOutCnt)
                                     && $stable(captureCnt) && $stable(totalCnt)));

  // R5
  total_matches_parts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(totalCnt) == 32'(shiftInCnt) + 32'(shiftOutCnt) + 32'(captureCnt));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(shiftInCnt) <= SHMAX) && (32'(shiftOutCnt) <= SHMAX)
    && (32'(captureCnt) <= CHAIN_LEN));

  // R8
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clear |=> (totalCnt == '0));
endmodule

// File: rtl/scan_activity_est.sv
module scan_activity_est #(
  parameter int CHAIN_LEN = 16,
  localparam int IDXW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int SHW  = $clog2(CHAIN_LEN * (CHAIN_LEN - 1) / 2 + 1),
  localparam int CAPW = $clog2(CHAIN_LEN + 1),
  localparam int TOTW = $clog2(CHAIN_LEN * CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] loadVec,
  input  logic [CHAIN_LEN-1:0] respVec,
  output logic [SHW-1:0]       shiftInCnt,
  output logic [SHW-1:0]       shiftOutCnt,
  output logic [CAPW-1:0]      captureCnt,
  output logic [TOTW-1:0]      totalCnt,
  output logic                 done
);
  scan_activity_pkg::estCtrl_t ctrl;
  logic [IDXW-1:0]             idx;

  scan_activity_ctrl #(.CHAIN_LEN(CHAIN_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctrl(ctrl), .idx(idx), .done(done)
  );

  scan_activity_dp #(.CHAIN_LEN(CHAIN_LEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .idx(idx),
    .loadVec(loadVec), .respVec(respVec),
    .shiftInCnt(shiftInCnt), .shiftOutCnt(shiftOutCnt),
    .captureCnt(captureCnt), .totalCnt(totalCnt)
  );
endmodule

// File: tb/scan_activity_est_tb_top.sv
module scan_activity_est_tb_top;
  localparam int N    = 16;
  localparam int SHW  = $clog2(N * (N - 1) / 2 + 1);
  localparam int CAPW = $clog2(N + 1);
  localparam int TOTW = $clog2(N * N + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [N-1:0] loadVec = '0, respVec = '0;
  logic [SHW-1:0] shiftInCnt, shiftOutCnt;
  logic [CAPW-1:0] captureCnt;
  logic [TOTW-1:0] totalCnt;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  scan_activity_est #(.CHAIN_LEN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .loadVec(loadVec), .respVec(respVec),
    .shiftInCnt(shiftInCnt), .shiftOutCnt(shiftOutCnt), .captureCnt(captureCnt),
    .totalCnt(totalCnt), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refIn(input logic [N-1:0] v);
    int s = 0;
    for (int p = 1; p < N; p++) if (v[p-1] != v[p]) s += N - p;
    return s;
  endfunction

  function automatic int refOut(input logic [N-1:0] v);
    int s = 0;
    for (int p = 1; p < N; p++) if (v[p-1] != v[p]) s += p;
    return s;
  endfunction

  function automatic int refCap(input logic [N-1:0] a, input logic [N-1:0] b);
    int s = 0;
    for (int i = 0; i < N; i++) if (a[i] != b[i]) s++;
    return s;
  endfunction

  // Pulse start at a negedge so it is sampled by the next posedge.
  task automatic kick(input logic [N-1:0] lv, input logic [N-1:0] rv);
    loadVec = lv; respVec = rv; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
  endtask

  task automatic checkResult(input logic [N-1:0] lv, input logic [N-1:0] rv);
    int ei = refIn(lv), eo = refOut(rv), ec = refCap(lv, rv);
    check("R2", int'(shiftInCnt), ei);
    check("R3", int'(shiftOutCnt), eo);
    check("R4", int'(captureCnt), ec);
    check("R5", int'(totalCnt), ei + eo + ec);
  endtask

  // Runs one evaluation and checks done timing (R6) and results.
  task automatic runVec(input logic [N-1:0] lv, input logic [N-1:0] rv);
    kick(lv, rv);
    loadVec = ~lv; respVec = ~rv; // R7: post-start input changes ignored
    for (int c = 1; c < N; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == N - 1) check("R6 low before last", int'(done), 0);
    end
    @(posedge clk); @(negedge clk);
    check("R6 done", int'(done), 1);
    checkResult(lv, rv);
  endtask

  task automatic tReset;
    check("R1 done", int'(done), 0);
    check("R1 total", int'(totalCnt), 0);
    check("R1 in", int'(shiftInCnt), 0);
    check("R1 cap", int'(captureCnt), 0);
  endtask

  task automatic tEdges;
    // single transition at pair 1 -> weights N-1 and 1; at pair N-1 -> 1 and N-1
    runVec(16'h0001, 16'h8000);
    runVec(16'hFFFE, 16'h7FFF);
    runVec('0, '0);
  endtask

  task automatic tWorst; // R9
    runVec(16'h5555, 16'hAAAA);
    check("R9 in max", int'(shiftInCnt), N * (N - 1) / 2);
    check("R9 out max", int'(shiftOutCnt), N * (N - 1) / 2);
  endtask

  task automatic tRandom;
    for (int k = 0; k < 6; k++) runVec(N'($urandom), N'($urandom));
  endtask

  task automatic tHold; // R7
    logic [TOTW-1:0] t0;
    runVec(16'h0F3C, 16'h1234);
    t0 = totalCnt;
    repeat (20) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 total held", int'(totalCnt), int'(t0));
    checkResult(16'h0F3C, 16'h1234);
  endtask

  task automatic tRestart; // R8
    kick(16'hFFFF, 16'h0000);
    repeat (4) @(negedge clk);
    kick(16'h00F0, 16'hC003);
    check("R8 cleared", int'(totalCnt), 0);
    for (int c = 1; c < N; c++) @(negedge clk);
    check("R8 not done", int'(done), 0);
    @(negedge clk);
    check("R8 done", int'(done), 1);
    checkResult(16'h00F0, 16'hC003);
    kick(16'h0001, 16'h0001);
    check("R8 done cleared", int'(done), 0);
    repeat (N) @(negedge clk);
    checkResult(16'h0001, 16'h0001);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tReset();
    tEdges();
    tWorst();
    tRandom();
    tHold();
    tRestart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule